// File: doc/BRIEF.md
# Register-Driven CRC-16 Engine

This block computes a 16-bit frame check sequence for infrared link frames under software control. Software clears the engine through a control register, then writes the frame one item per write into a data register. Each write folds the low byte of the item into the running CRC in a single clock. Software can read back how many items were taken in since the last clear, and can read the finished check value from a result register.

The CRC uses the generator x^16 + x^12 + x^5 + 1 and processes each byte least-significant bit first. The internal state starts at 0x0000 and the result register shows the state XOR 0xFCDE. With these values, clearing the engine and writing 0xCC, 0xF5, 0xF1 and 0xA7 gives 0x51DF, which is the known answer used to check the engine. The item counter is 12 bits wide and stops at its maximum value.

Top module: `crc16_engine`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000 and the result register (address 2) reads 0xFCDE.
- R2: A write to address 0 with bit 15 set clears both the CRC state and the item count. From the next cycle, address 0 reads 0x0000 and address 2 reads 0xFCDE.
- R3: On a read of address 0, bit 15 (the clear bit) and bits 14:12 always read 0. Bits 11:0 hold the item count.
- R4: A write to address 0 with bit 15 clear changes neither the result nor the count.
- R5: A write to address 1 (the data register) absorbs bits 7:0 into the CRC in that cycle. The state update is reflected, with polynomial constant 0x8408, starting state 0x0000 and output XOR 0xFCDE. The new result is readable on address 2 in the next cycle.
- R6: Bits 11:8 and 15:12 of a data write have no effect on the result.
- R7: Each data write raises the count in control bits 11:0 by one.
- R8: The count saturates at 0xFFF. Further data writes still update the CRC but leave the count at 0xFFF.
- R9: Clear, then data writes 0xCC, 0xF5, 0xF1, 0xA7, make the count read 4 and the result read 0x51DF.
- R10: A write to address 2 or 3 changes neither the result nor the count. Reads of addresses 1 and 3 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one register write per cycle |
| wrAddr | input | 2 | Write address: 0 control, 1 data, 2 result, 3 unmapped |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address, same map as writes |
| rdData | output | 16 | Read data, combinational from rdAddr |

## Verification
A write is taken at a clock edge, and its effect on the count and on the result is visible through the read mux from that edge onward. This means every read that follows a write by one cycle must already see the new value. The bench applies each write for exactly one cycle and issues each read in the cycle after. It queues the expected word when the read is issued and compares it at the falling edge of the same cycle, so the comparison always falls one edge after the write that produced the value. The expected words come from a bitwise reference model that runs in step with the writes. The bench also replays the fixed four-byte sequence against the constant 0x51DF.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 12;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 2;
  localparam logic [CRC_W-1:0] POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] INIT_VAL = 16'h0000;
  localparam logic [CRC_W-1:0] XOR_OUT  = 16'hFCDE;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RESULT = 2'd2;
  localparam int CLEAR_BIT = 15;

  typedef struct packed {
    logic              clearAll;
    logic              absorb;
    logic [BYTE_W-1:0] item;
  } crcStrobes_t;
endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CNT_W-1:0]  itemCount,
  input  logic [CRC_W-1:0]  crcResult,
  output crcStrobes_t       strobes,
  output logic [REG_W-1:0]  rdData
);
  localparam int PAD_W = REG_W - CNT_W;

  always_comb begin
    strobes.clearAll = wrEn && (wrAddr == ADDR_CTRL) && wrData[CLEAR_BIT];
    strobes.absorb   = wrEn && (wrAddr == ADDR_DATA);
    strobes.item     = wrData[BYTE_W-1:0];
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL:   rdData = {{PAD_W{1'b0}}, itemCount};
      ADDR_RESULT: rdData = crcResult;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobes_t      strobes,
  output logic [CRC_W-1:0] crcState,
  output logic [CNT_W-1:0] itemCount,
  output logic [CRC_W-1:0] crcResult
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CRC_W-1:0] bitStage [BYTE_W+1];

  assign bitStage[0] = crcState ^ {{(CRC_W-BYTE_W){1'b0}}, strobes.item};

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign bitStage[b+1] = bitStage[b][0] ? ((bitStage[b] >> 1) ^ POLY_REV)
                                          : (bitStage[b] >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcState  <= INIT_VAL;
      itemCount <= '0;
    end else if (strobes.clearAll) begin
      crcState  <= INIT_VAL;
      itemCount <= '0;
    end else if (strobes.absorb) begin
      crcState <= bitStage[BYTE_W];
      if (itemCount != CNT_MAX) itemCount <= itemCount + 1'b1;
    end
  end

  assign crcResult = crcState ^ XOR_OUT;
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData
);
  crcStrobes_t      strobes;
  logic [CRC_W-1:0] crcState;
  logic [CRC_W-1:0] crcResult;
  logic [CNT_W-1:0] itemCount;
  logic             clearAll;
  logic             absorb;

  assign clearAll = strobes.clearAll;
  assign absorb   = strobes.absorb;

  crc16_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .itemCount (itemCount),
    .crcResult (crcResult),
    .strobes   (strobes),
    .rdData    (rdData)
  );

  crc16_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .crcState  (crcState),
    .itemCount (itemCount),
    .crcResult (crcResult)
  );
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk
  import crc16_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clearAll,
  input logic              absorb,
  input logic [CRC_W-1:0]  crcState,
  input logic [CNT_W-1:0]  itemCount,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [REG_W-1:0]  rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (crcState == INIT_VAL) && (itemCount == '0));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (absorb && !clearAll && itemCount != CNT_MAX) |=>
      itemCount == CNT_W'($past(itemCount) + 1'b1));

  // R8
  count_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (absorb && itemCount == CNT_MAX) |=> itemCount == CNT_MAX);

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!absorb && !clearAll) |=> $stable(crcState) && $stable(itemCount));

  // R3
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_CTRL) |-> rdData[REG_W-1:CNT_W] == '0);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(absorb && clearAll));
endmodule

bind crc16_engine crc16_engine_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clearAll  (clearAll),
  .absorb    (absorb),
  .crcState  (crcState),
  .itemCount (itemCount),
  .rdAddr    (rdAddr),
  .rdData    (rdData)
);

// File: tb/tb_crc16_engine.sv
module tb_crc16_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        chkValid = 1'b0;

  int vecCount = 0;
  int errCount = 0;
  bit done = 1'b0;

  logic [15:0] expQ [$];
  string       tagQ [$];

  logic [15:0] mdlState = 16'h0000;
  int          mdlCount = 0;

  always #4 clk = ~clk;

  crc16_engine dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [15:0] refStep(logic [15:0] s, logic [7:0] b);
    logic [15:0] c;
    c = s;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'h8408;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [15:0] mdlResult();
    return mdlState ^ 16'hFCDE;
  endfunction

  function automatic logic [15:0] mdlCtrl();
    return 16'(mdlCount);
  endfunction

  // monitor: pops and compares in the cycle the read is issued
  always @(negedge clk) begin
    if (chkValid && expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      vecCount++;
      if (rdData !== e) begin
        errCount++;
        $display("FAIL %s: got %h expected %h", t, rdData, e);
      end
    end
  end

  task automatic doWrite(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    if (a == 2'd0 && d[15]) begin
      mdlState = 16'h0000; mdlCount = 0;
    end else if (a == 2'd1) begin
      mdlState = refStep(mdlState, d[7:0]);
      if (mdlCount < 4095) mdlCount++;
    end
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [15:0] e, input string t);
    if (!wrEn) begin
      @(posedge clk); #1;
    end
    rdAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    chkValid = 1'b1;
    @(posedge clk); #1;
    chkValid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    readCheck(2'd0, 16'h0000, "R1 ctrl after reset");
    readCheck(2'd2, 16'hFCDE, "R1 result after reset");

    // R9 known answer
    doWrite(2'd0, 16'h8000);
    doWrite(2'd1, 16'h00CC);
    readCheck(2'd2, mdlResult(), "R5 result after first byte");
    doWrite(2'd1, 16'h00F5);
    doWrite(2'd1, 16'h00F1);
    doWrite(2'd1, 16'h00A7);
    readCheck(2'd0, 16'h0004, "R9 count after known sequence");
    readCheck(2'd2, 16'h51DF, "R9 known answer");
    readCheck(2'd2, mdlResult(), "R5 reference model agrees");

    // R3 clear bit reads zero, R4 ctrl write without clear is ignored
    doWrite(2'd0, 16'h7FFF);
    readCheck(2'd0, 16'h0004, "R4 R3 ctrl after non-clear write");
    readCheck(2'd2, 16'h51DF, "R4 result after non-clear write");

    // R10 writes to result / unmapped ignored, other reads zero
    doWrite(2'd2, 16'h1234);
    doWrite(2'd3, 16'hFFFF);
    readCheck(2'd2, 16'h51DF, "R10 result after stray writes");
    readCheck(2'd0, 16'h0004, "R10 count after stray writes");
    readCheck(2'd1, 16'h0000, "R10 data register reads zero");
    readCheck(2'd3, 16'h0000, "R10 unmapped reads zero");

    // R2 clear
    doWrite(2'd0, 16'h8ABC);
    readCheck(2'd0, 16'h0000, "R2 count cleared");
    readCheck(2'd2, 16'hFCDE, "R2 result cleared");

    // R6 upper bits ignored: same bytes with junk in upper bits
    doWrite(2'd1, 16'hFFCC);
    doWrite(2'd1, 16'h0AF5);
    doWrite(2'd1, 16'h53F1);
    doWrite(2'd1, 16'hF0A7);
    readCheck(2'd2, 16'h51DF, "R6 upper item bits ignored");

    // R5 R7 varied patterns
    doWrite(2'd0, 16'h8000);
    for (int i = 0; i < 20; i++) begin
      doWrite(2'd1, 16'((i * 37 + 11) & 16'hFFFF));
      readCheck(2'd2, mdlResult(), "R5 pattern result");
      readCheck(2'd0, mdlCtrl(), "R7 pattern count");
    end
    doWrite(2'd1, 16'h0000);
    doWrite(2'd1, 16'h00FF);
    readCheck(2'd2, mdlResult(), "R5 zero and ones bytes");

    // R8 saturation
    doWrite(2'd0, 16'h8000);
    for (int i = 0; i < 4094; i++) begin
      doWrite(2'd1, 16'(i & 8'hFF));
    end
    readCheck(2'd0, 16'h0FFE, "R7 count just below max");
    doWrite(2'd1, 16'h005A);
    readCheck(2'd0, 16'h0FFF, "R8 count reaches max");
    doWrite(2'd1, 16'h00A5);
    readCheck(2'd0, 16'h0FFF, "R8 count holds at max");
    readCheck(2'd2, mdlResult(), "R8 crc still updates at max");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule